// File: doc/BRIEF.md
# Shared-Bus Request/Grant Round-Robin Arbiter

This block decides which of several memory controllers may drive a single shared external bus at a time. A controller raises its request line to ask for the bus and keeps it raised for as long as it is transferring. The arbiter answers on that controller's grant line. A controller owns the bus exactly while its grant is high, and it gives the bus back by lowering its request. The arbiter never takes ownership away on its own.

After every release the arbiter holds back the next grant for a programmable dead time. This gives the bus time to settle before the next owner starts to drive it. When the dead time ends, requesters are served in round-robin order: the controller that did not own the bus last is preferred. A controller that just released and is the only requester is granted again. Arbitration runs only while the multiplex enable input is high. The owner index output steers the shared port of the pin routing matrix.

Top module: `busmux_rr_arbiter`

## Requirements
- R1: At most one bit of `ack` is high in any cycle.
- R2: While the multiplex enable is 1, a controller whose `ack` and `req` bits are both high at a clock edge keeps its `ack` high after that edge.
- R3: When the owner's `req` bit is sampled low at a clock edge, its `ack` is low after that edge, and the dead time starts at that edge.
- R4: With dead-time field G (8 bits, 0 to 255) captured at the release edge, no new `ack` rises before the (G+1)-th clock edge after the release edge. If a controller is requesting at that edge, its `ack` rises there.
- R5: While `mux_en` is sampled 0 at an edge, all `ack` bits are 0 after that edge and no grant is made. A dead time that is still running is discarded.
- R6: When the bus is idle and no dead time is running, a requester sampled high at an edge is granted at that edge. `ack` only ever rises for a controller whose `req` was high at the granting edge.
- R7: When several controllers request at a granting edge, the winner is the first requester after the last owner in rising index order, wrapping around. With two controllers, the one that did not own the bus last wins. After reset, index 0 has priority.
- R8: A controller that released the bus and is then the only requester is granted again once the dead time has elapsed.
- R9: `owner_idx` equals the index of the controller whose `ack` is high. While the bus is idle it holds the last owner. After reset it holds NUM_REQ-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_en | input | 1 | Multiplex enable; 0 suppresses all grants |
| gap_cfg | input | GAP_W (8) | Dead-time field G; the dead time lasts G+1 cycles |
| req | input | NUM_REQ (2) | Per-controller bus request |
| ack | output | NUM_REQ (2) | Per-controller bus grant, one-hot or zero |
| owner_idx | output | IDX_W (1) | Current or last owner; selects the shared port of the routing matrix |

## Verification
The arbiter is driven with simultaneous requests straight out of reset, which shows whether the reset priority is honoured. It is then driven with a handover to a waiting peer, which shows whether round-robin order is kept, and with a release by a sole requester, which shows whether the releasing controller can win the bus again. Dead-time measurements at field values 0, 2, 3, 5 and 255 show an off-by-one in the counter and whether the field is captured correctly. Long random request traffic, with random dead times and occasional toggling of the enable, is compared each cycle against a behavioural model in the bench. This separates hold, release, disable and tie-break errors that the directed cases may not reach.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
   localparam int DEF_NUM_REQ = 2;
   localparam int DEF_GAP_W   = 8;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/busarb_rr_pick.sv
module busarb_rr_pick
   import busarb_pkg::*;
#(
   parameter int NUM_REQ = DEF_NUM_REQ,
   parameter int IDX_W   = idx_width(NUM_REQ)
) (
   input  logic [NUM_REQ-1:0] req,
   input  logic [IDX_W-1:0]   last,
   output logic               any,
   output logic [IDX_W-1:0]   win
);
   generate
      if (NUM_REQ == 2) begin : g_pair
         // two requesters: a tie goes to the one that did not own last
         always_comb begin
            any = |req;
            if (req[0] && req[1]) win = ~last;
            else                  win = IDX_W'(req[1]);
         end
      end else begin : g_rotate
         // scan from last+1 with wrap; first requester found wins
         always_comb begin
            any = 1'b0;
            win = '0;
            for (int k = 1; k <= NUM_REQ; k++) begin
               int j;
               j = (int'(last) + k) % NUM_REQ;
               if (!any && req[j]) begin
                  any = 1'b1;
                  win = IDX_W'(j);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/busarb_gap_timer.sv
module busarb_gap_timer
   import busarb_pkg::*;
#(
   parameter int GAP_W = DEF_GAP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             start,
   input  logic [GAP_W-1:0] load_val,
   output logic             gap_ok
);
   logic             busy;
   logic [GAP_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (clr) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else begin
         if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
         end
         if (start) begin
            busy <= 1'b1;
            cnt  <= load_val;
         end
      end
   end

   // the last counted edge is itself an edge at which a grant may be made
   assign gap_ok = !busy || (cnt == '0);

   a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start && !clr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !clr) |=> (busy && cnt == $past(load_val)));

   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> gap_ok);
endmodule

// File: rtl/busarb_owner.sv
module busarb_owner
   import busarb_pkg::*;
#(
   parameter int NUM_REQ = DEF_NUM_REQ,
   parameter int IDX_W   = idx_width(NUM_REQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [NUM_REQ-1:0] req,
   input  logic               gap_ok,
   input  logic               any,
   input  logic [IDX_W-1:0]   win,
   output logic [NUM_REQ-1:0] ack,
   output logic [IDX_W-1:0]   last,
   output logic               release_p
);
   logic busy_bus;

   assign busy_bus  = |ack;
   assign release_p = en && busy_bus && !req[last];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack  <= '0;
         last <= IDX_W'(NUM_REQ - 1);
      end else if (!en) begin
         ack  <= '0;
      end else if (busy_bus) begin
         if (!req[last]) ack <= '0;
      end else if (gap_ok && any) begin
         ack  <= NUM_REQ'(1) << win;
         last <= win;
      end
   end

   generate
      for (genvar i = 0; i < NUM_REQ; i++) begin : g_chk
         a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (en && ack[i] && req[i]) |=> ack[i]);
         a_r3_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[i] && !req[i]) |=> !ack[i]);
         a_r6_grant_to_req: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ack[i]) |-> $past(req[i]));
         a_r9_owner_match: assert property (@(posedge clk) disable iff (!rst_n)
            ack[i] |-> (last == IDX_W'(i)));
      end
   endgenerate
endmodule

// File: rtl/busmux_rr_arbiter.sv
module busmux_rr_arbiter
   import busarb_pkg::*;
#(
   parameter int NUM_REQ = DEF_NUM_REQ,
   parameter int GAP_W   = DEF_GAP_W,
   localparam int IDX_W  = idx_width(NUM_REQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mux_en,
   input  logic [GAP_W-1:0]   gap_cfg,
   input  logic [NUM_REQ-1:0] req,
   output logic [NUM_REQ-1:0] ack,
   output logic [IDX_W-1:0]   owner_idx
);
   generate
      if (NUM_REQ < 2) begin : g_bad_num
         $error("busmux_rr_arbiter: NUM_REQ must be at least 2");
      end
      if (GAP_W < 1 || GAP_W > 16) begin : g_bad_gap
         $error("busmux_rr_arbiter: GAP_W must be 1..16");
      end
   endgenerate

   logic             any;
   logic [IDX_W-1:0] win;
   logic             gap_ok;
   logic             release_p;

   busarb_rr_pick #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) i_pick (
      .req  (req),
      .last (owner_idx),
      .any  (any),
      .win  (win)
   );

   busarb_gap_timer #(.GAP_W(GAP_W)) i_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!mux_en),
      .start    (release_p),
      .load_val (gap_cfg),
      .gap_ok   (gap_ok)
   );

   busarb_owner #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) i_owner (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (mux_en),
      .req       (req),
      .gap_ok    (gap_ok),
      .any       (any),
      .win       (win),
      .ack       (ack),
      .last      (owner_idx),
      .release_p (release_p)
   );

   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack));

   a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !mux_en |=> (ack == '0));

   a_r4_no_early_grant: assert property (@(posedge clk) disable iff (!rst_n)
      ((|ack) && !$past(|ack)) |-> $past(gap_ok));
endmodule

// File: tb/test_busmux_rr_arbiter.sv
`timescale 1ns/1ps
module test_busmux_rr_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mux_en = 1'b0;
   logic [7:0] gap = 8'd0;
   logic [1:0] req = 2'b00;
   logic [1:0] ack;
   logic       owner;

   int n_chk = 0;
   int n_bad = 0;

   // behavioural model state
   logic [1:0] m_ack;
   logic       m_last;
   logic       m_busy;
   int         m_cnt;

   always #2.5 clk = ~clk;

   busmux_rr_arbiter i_busmux_rr_arbiter (
      .clk(clk), .rst_n(rst_n), .mux_en(mux_en), .gap_cfg(gap),
      .req(req), .ack(ack), .owner_idx(owner)
   );

   function automatic logic pick(input logic [1:0] r, input logic last);
      if (r == 2'b11) return ~last;
      return r[1];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ack = 2'b00; m_last = 1'b1; m_busy = 1'b0; m_cnt = 0;
      end else if (!mux_en) begin
         m_ack = 2'b00; m_busy = 1'b0; m_cnt = 0;
      end else begin
         logic ok;
         ok = !m_busy || m_cnt == 0;
         if (m_busy) begin
            if (m_cnt == 0) m_busy = 1'b0;
            else            m_cnt  = m_cnt - 1;
         end
         if (m_ack != 2'b00) begin
            if (!req[m_last]) begin
               m_ack = 2'b00; m_busy = 1'b1; m_cnt = int'(gap);
            end
         end else if (ok && req != 2'b00) begin
            m_last = pick(req, m_last);
            m_ack  = 2'b01 << m_last;
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // one cycle: wait for the next falling edge, compare against the model
   task automatic cyc();
      @(negedge clk);
      check("R1 ack onehot0", int'(ack == 2'b00 || ack == 2'b01 || ack == 2'b10), 1);
      check("R2 R3 R6 R7 R8 model ack", int'(ack), int'(m_ack));
      check("R9 owner model", int'(owner), int'(m_last));
   endtask

   // drop the owner's request; count falling edges until 'who' is granted
   task automatic measure(input logic [1:0] new_req, input int who, output int n);
      req = new_req;
      n = 0;
      for (int k = 0; k < 300; k++) begin
         cyc();
         n++;
         if (k == 0) check("R3 ack low after release", int'(ack), 0);
         if (ack[who]) break;
      end
   endtask

   initial begin
      #(5.0 * 200000);
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int n;
      void'($urandom(32'h00c0ffee));
      repeat (3) @(negedge clk);
      check("reset ack R6", int'(ack), 0);
      check("reset owner R9", int'(owner), 1);

      // R5: enable low, both requesting, no grant
      rst_n = 1'b1; mux_en = 1'b0; req = 2'b11;
      repeat (4) cyc();
      check("R5 no grant while disabled", int'(ack), 0);

      // R7: simultaneous after reset -> index 0
      mux_en = 1'b1;
      cyc();
      check("R7 reset priority", int'(ack), 1);
      check("R9 owner follows ack", int'(owner), 0);

      // R2: held while request stays high
      repeat (3) cyc();
      check("R2 hold", int'(ack), 1);

      // R4: gap 5 handover to waiting peer
      gap = 8'd5;
      measure(2'b10, 1, n);
      check("R4 gap 5 edges", n - 1, 6);

      // R4: gap 0
      gap = 8'd0;
      req = 2'b11;
      cyc();
      measure(2'b01, 0, n);
      check("R4 gap 0 edges", n - 1, 1);

      // R8: sole requester re-granted after gap 3
      gap = 8'd3;
      req = 2'b00;
      cyc();
      check("R3 drop", int'(ack), 0);
      req = 2'b01;
      n = 1;
      for (int k = 0; k < 20; k++) begin
         cyc(); n++;
         if (ack[0]) break;
      end
      check("R8 regrant after gap 3", n - 1, 4);
      check("R8 regrant owner", int'(owner), 0);

      // R7: both pending at gap end, last owner 0 -> 1 wins
      gap = 8'd2;
      req = 2'b10;
      cyc();
      req = 2'b11;
      repeat (4) cyc();
      check("R7 round robin tie", int'(ack), 2);

      // R4: maximum gap 255
      gap = 8'd255;
      measure(2'b01, 0, n);
      check("R4 gap 255 edges", n - 1, 256);

      // R5: disable during ownership
      mux_en = 1'b0;
      cyc();
      check("R5 ack cleared on disable", int'(ack), 0);
      mux_en = 1'b1;
      req = 2'b00;
      cyc();

      // random traffic against the model
      for (int t = 0; t < 4000; t++) begin
         logic [1:0] r;
         r = req;
         for (int i = 0; i < 2; i++) begin
            if (!r[i]) begin
               if ($urandom % 5 == 0) r[i] = 1'b1;
            end else if (m_ack[i]) begin
               if ($urandom % 7 == 0) r[i] = 1'b0;
            end
         end
         req = r;
         if ($urandom % 40 == 0) gap = 8'($urandom % 12);
         if ($urandom % 300 == 0) mux_en = ~mux_en;
         else if (!mux_en && $urandom % 10 == 0) mux_en = 1'b1;
         cyc();
      end
      summary();
   end
endmodule